// File: doc/BRIEF.md
# Receive Byte Queue with Dual Fill-Level Thresholds

This block buffers bytes arriving from a serial receiver in a 64-entry first-in first-out store, and the CPU drains them through a read port. A 16-bit control word, written and read back by the CPU, selects two independent fill levels. The first drives a data-ready indication when enough bytes are waiting. The second drives a flow-control request-to-send line that tells the far end to pause once the queue passes a higher mark.

The control word also has a level-held receive flush bit, a transmit flush bit, a loopback bit and a modem-control gate for the request-to-send line. The transmit flush bit appears as a one-cycle pulse for a neighbouring transmit path. The loopback bit is passed out to the serial routing logic. The queue count and both indications are registered and always describe the same cycle.

Top module: `uart_rxq_ctl`

## Requirements
- R1: After synchronous reset the control word reads 0, rx_count is 0, and data_ready, rts_out, rx_overrun, tx_flush and loopback_en are all 0.
- R2: A control write stores bits 10..0, and cfg_rd_data returns them from the next cycle. Bits 15..11 always read 0. Field layout: [10:8] send-pause level code, [7:6] ready level code, [5:4] transmit level code (stored only), [3] modem-control gate, [2] transmit flush, [1] receive flush, [0] loopback.
- R3: Each accepted rx_push raises rx_count by one. A cpu_pop with rx_count above 0 lowers it by one and presents the oldest stored byte on cpu_byte in the cycle after the pop.
- R4: An rx_push while rx_count is 64 and no pop occurs is dropped, and rx_overrun goes high for one cycle. A push and a pop in the same cycle at count 64 are both accepted, and the count stays at 64.
- R5: data_ready is 1 exactly when rx_count is greater than or equal to the ready level. Ready level code 0→1, 1→16, 2→32, 3→48.
- R6: When the modem-control gate is 1, rts_out is 1 exactly when rx_count is strictly greater than the send-pause level. Send-pause code 0→63, 1→1, 2→8, 3→16, 4→32, 5→48, 6→54, 7→60.
- R7: When the modem-control gate is 0, rts_out is 0 whatever the count.
- R8: A write that sets the receive flush bit empties the queue at that edge. While the bit stays 1, rx_count stays 0, pushes are ignored without overrun, and pops return 0.
- R9: A pop of an empty queue leaves rx_count at 0 and gives cpu_byte 0 in the following cycle.
- R10: tx_flush is 1 for one cycle after each control write with bit 2 set. loopback_en follows stored bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Stored control word |
| rx_push | input | 1 | Receiver byte strobe |
| rx_byte | input | 8 | Receiver byte |
| rx_overrun | output | 1 | One-cycle pulse on a dropped push |
| cpu_pop | input | 1 | CPU read strobe |
| cpu_byte | output | 8 | Byte taken by the previous pop |
| rx_count | output | 7 | Bytes held, 0 to 64 |
| data_ready | output | 1 | Count at or above the ready level |
| rts_out | output | 1 | Count above the send-pause level, gated |
| tx_flush | output | 1 | Transmit flush pulse |
| loopback_en | output | 1 | Loopback routing enable |

## Verification
The push from the receiver and the pop from the CPU can land in the same cycle, and this matters most when the queue is full. The bench fills the queue to 64 and drives both strobes together. It expects no overrun, an unchanged count, the oldest byte on cpu_byte, and the new byte last in the drained order. It also writes the receive flush bit while bytes are stored, and expects the flush to win over any push that follows.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef struct packed {
    logic [4:0] rsvd;
    logic [2:0] rts_sel;
    logic [1:0] rdy_sel;
    logic [1:0] tx_trig;
    logic       mce;
    logic       tx_clr;
    logic       rx_clr;
    logic       loop;
  } fcr_t;

  localparam logic [15:0] FCR_WMASK = 16'h07FF;

  function automatic int unsigned rdy_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned rts_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return 63;
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      3'd5:    return 48;
      3'd6:    return 54;
      default: return 60;
    endcase
  endfunction

endpackage

// File: rtl/uart_rxq_cfg.sv
module uart_rxq_cfg
  import uart_rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output fcr_t        fcr_q,
  output logic        rx_clr_nx,
  output logic [2:0]  rts_sel_nx,
  output logic [1:0]  rdy_sel_nx,
  output logic        mce_nx,
  output logic        tx_flush
);

  fcr_t fcr_nx;

  always_comb begin
    fcr_nx = fcr_q;
    if (wr_en) fcr_nx = fcr_t'(wr_data & FCR_WMASK);
  end

  assign rx_clr_nx  = fcr_nx.rx_clr;
  assign rts_sel_nx = fcr_nx.rts_sel;
  assign rdy_sel_nx = fcr_nx.rdy_sel;
  assign mce_nx     = fcr_nx.mce;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcr_q    <= '0;
      tx_flush <= 1'b0;
    end else begin
      fcr_q    <= fcr_nx;
      tx_flush <= wr_en & wr_data[2];
    end
  end

endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     count_nx,
  output logic              overrun
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [DATA_W-1:0] rd_q;
  logic              zero_q;
  logic              do_pop, do_push, full;

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !clr && (count != '0);
  assign do_push = push && !clr && (!full || do_pop);

  always_comb begin
    count_nx = count;
    if (clr)                      count_nx = '0;
    else if (do_push && !do_pop)  count_nx = count + CW'(1);
    else if (!do_push && do_pop)  count_nx = count - CW'(1);
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
    if (do_pop)  rd_q      <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      zero_q  <= 1'b1;
      overrun <= 1'b0;
    end else begin
      count   <= count_nx;
      overrun <= push && !clr && !do_push;
      if (pop) zero_q <= !do_pop;
      if (clr) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (do_push) wptr <= bump(wptr);
        if (do_pop)  rptr <= bump(rptr);
      end
    end
  end

  assign pop_data = zero_q ? '0 : rd_q;

endmodule

// File: rtl/uart_rxq_levels.sv
module uart_rxq_levels
  import uart_rxq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nx,
  input  logic [1:0]    rdy_sel,
  input  logic [2:0]    rts_sel,
  input  logic          mce,
  output logic          data_ready,
  output logic          rts_out
);

  logic rdy_nx, rts_nx;

  assign rdy_nx = int'(count_nx) >= int'(rdy_level(rdy_sel));
  assign rts_nx = mce && (int'(count_nx) > int'(rts_level(rts_sel)));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      rts_out    <= 1'b0;
    end else begin
      data_ready <= rdy_nx;
      rts_out    <= rts_nx;
    end
  end

endmodule

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_overrun,
  input  logic              cpu_pop,
  output logic [DATA_W-1:0] cpu_byte,
  output logic [CW-1:0]     rx_count,
  output logic              data_ready,
  output logic              rts_out,
  output logic              tx_flush,
  output logic              loopback_en
);

  fcr_t          fcr_q;
  logic          rx_clr_nx, mce_nx;
  logic [2:0]    rts_sel_nx;
  logic [1:0]    rdy_sel_nx;
  logic [CW-1:0] count_nx;

  uart_rxq_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .fcr_q      (fcr_q),
    .rx_clr_nx  (rx_clr_nx),
    .rts_sel_nx (rts_sel_nx),
    .rdy_sel_nx (rdy_sel_nx),
    .mce_nx     (mce_nx),
    .tx_flush   (tx_flush)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (rx_clr_nx),
    .push      (rx_push),
    .push_data (rx_byte),
    .pop       (cpu_pop),
    .pop_data  (cpu_byte),
    .count     (rx_count),
    .count_nx  (count_nx),
    .overrun   (rx_overrun)
  );

  uart_rxq_levels #(.CW(CW)) u_levels (
    .clk        (clk),
    .rst        (rst),
    .count_nx   (count_nx),
    .rdy_sel    (rdy_sel_nx),
    .rts_sel    (rts_sel_nx),
    .mce        (mce_nx),
    .data_ready (data_ready),
    .rts_out    (rts_out)
  );

  assign cfg_rd_data = fcr_q;
  assign loopback_en = fcr_q.loop;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr_en,
  input logic [15:0]   cfg_wr_data,
  input logic [15:0]   cfg_rd_data,
  input logic [CW-1:0] rx_count,
  input logic          rx_overrun,
  input logic          data_ready,
  input logic          rts_out,
  input logic          tx_flush
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[15:11] == 5'd0); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(DEPTH)); // R3

  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> ($past(rx_count) == CW'(DEPTH))); // R4

  AST_READY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (rx_count != '0)); // R5

  AST_RTS_GATED: assert property (@(posedge clk) disable iff (rst)
    rts_out |-> cfg_rd_data[3]); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[1] |-> (rx_count == '0 && !rx_overrun)); // R8

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> ($past(cfg_wr_en) && $past(cfg_wr_data[2]))); // R10

endmodule

bind uart_rxq_ctl uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun),
  .data_ready  (data_ready),
  .rts_out     (rts_out),
  .tx_flush    (tx_flush)
);

// File: tb/uart_rxq_ctl_test.sv
module uart_rxq_ctl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_overrun;
  logic        cpu_pop = 1'b0;
  logic [7:0]  cpu_byte;
  logic [6:0]  rx_count;
  logic        data_ready, rts_out, tx_flush, loopback_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model of stored bytes
  logic [7:0] mdl [64];
  int head = 0, tail = 0, fill = 0;

  always #2 clk = ~clk;

  uart_rxq_ctl uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_overrun(rx_overrun), .cpu_pop(cpu_pop), .cpu_byte(cpu_byte),
    .rx_count(rx_count), .data_ready(data_ready), .rts_out(rts_out),
    .tx_flush(tx_flush), .loopback_en(loopback_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl_rdy(input int code);
    return (code == 0) ? 1 : 16 * code;
  endfunction

  function automatic int lvl_rts(input int code);
    int t [8] = '{63, 1, 8, 16, 32, 48, 54, 60};
    return t[code];
  endfunction

  int cur_rdy = 0, cur_rts = 0, cur_mce = 0;

  task automatic chk_flags();
    chk("R5 data_ready", int'(data_ready), int'(fill >= lvl_rdy(cur_rdy)));
    if (cur_mce != 0)
      chk("R6 rts_out", int'(rts_out), int'(fill > lvl_rts(cur_rts)));
    else
      chk("R7 rts_out gated", int'(rts_out), 0);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cur_rts = int'(v[10:8]); cur_rdy = int'(v[7:6]); cur_mce = int'(v[3]);
  endtask

  task automatic push_b(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
    if (fill < 64) begin
      mdl[tail] = b; tail = (tail + 1) % 64; fill++;
    end
  endtask

  task automatic pop_b(input string req);
    @(negedge clk);
    cpu_pop = 1'b1;
    @(negedge clk);
    cpu_pop = 1'b0;
    if (fill > 0) begin
      chk(req, int'(cpu_byte), int'(mdl[head]));
      head = (head + 1) % 64; fill--;
    end else begin
      chk(req, int'(cpu_byte), 0);
    end
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", int'(cfg_rd_data), 0);
    chk("R1 count", int'(rx_count), 0);
    chk("R1 ready", int'(data_ready), 0);
    chk("R1 rts", int'(rts_out), 0);
    chk("R1 ovr", int'(rx_overrun), 0);
    chk("R1 txf", int'(tx_flush), 0);
    chk("R1 loop", int'(loopback_en), 0);

    // R9 empty pop
    pop_b("R9 empty pop byte");
    chk("R9 empty pop count", int'(rx_count), 0);

    // R2 readback with reserved bits
    wr_cfg(16'hFFFF);
    chk("R2 readback", int'(cfg_rd_data), 16'h07FF);
    wr_cfg(16'h0000);

    // R3 R5 R6: sweep every level pair over full fill and drain
    for (int rs = 0; rs < 8; rs++) begin
      for (int rd = 0; rd < 4; rd++) begin
        wr_cfg(16'((rs << 8) | (rd << 6) | 8));
        chk("R2 field", int'(cfg_rd_data), (rs << 8) | (rd << 6) | 8);
        for (int i = 0; i < 64; i++) begin
          push_b(8'((i * 37 + rs * 11 + rd) & 8'hFF));
          chk("R3 count up", int'(rx_count), fill);
          chk_flags();
        end
        for (int i = 0; i < 64; i++) begin
          pop_b("R3 order");
          chk("R3 count down", int'(rx_count), fill);
          chk_flags();
        end
      end
    end

    // R4 overrun and simultaneous push/pop at full
    wr_cfg(16'h0108);
    for (int i = 0; i < 64; i++) push_b(8'(i));
    chk("R6 full", int'(rts_out), 1);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = 8'hEE;
    @(negedge clk);
    rx_push = 1'b0;
    chk("R4 overrun pulse", int'(rx_overrun), 1);
    chk("R4 count held", int'(rx_count), 64);
    @(negedge clk);
    chk("R4 overrun one cycle", int'(rx_overrun), 0);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = 8'hA5; cpu_pop = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; cpu_pop = 1'b0;
    chk("R4 concurrent byte", int'(cpu_byte), int'(mdl[head]));
    head = (head + 1) % 64;
    mdl[tail] = 8'hA5; tail = (tail + 1) % 64;
    chk("R4 concurrent no overrun", int'(rx_overrun), 0);
    chk("R4 concurrent count", int'(rx_count), 64);

    // R7 gate off with full queue
    wr_cfg(16'h0100);
    chk("R7 gate off", int'(rts_out), 0);
    for (int i = 0; i < 63; i++) pop_b("R3 drain");
    pop_b("R4 new byte last");
    chk("R3 empty", int'(rx_count), 0);

    // R8 receive flush
    for (int i = 0; i < 5; i++) push_b(8'(i + 100));
    wr_cfg(16'h0002);
    fill = 0; head = 0; tail = 0;
    chk("R8 flush count", int'(rx_count), 0);
    chk("R8 flush ready", int'(data_ready), 0);
    push_b(8'h55);
    fill = 0; head = 0; tail = 0;
    chk("R8 push ignored", int'(rx_count), 0);
    chk("R8 no overrun", int'(rx_overrun), 0);
    pop_b("R8 pop zero");
    wr_cfg(16'h0000);
    push_b(8'h66);
    chk("R8 released", int'(rx_count), 1);
    pop_b("R8 released byte");

    // R10 transmit flush pulse and loopback
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 16'h0005;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R10 tx pulse", int'(tx_flush), 1);
    chk("R10 loopback", int'(loopback_en), 1);
    @(negedge clk);
    chk("R10 tx pulse ends", int'(tx_flush), 0);
    chk("R10 loopback held", int'(loopback_en), 1);
    wr_cfg(16'h0000);
    chk("R10 loopback off", int'(loopback_en), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule